// File: doc/BRIEF.md
# Opcode-Menu SPI Flash Command Sequencer

This block runs one SPI flash command at a time on behalf of software. Software fills an eight-entry table of opcode bytes, gives each entry a two-bit kind (read or write, with or without a 24-bit address), and loads a flash address and up to 64 bytes of staging data. One write to the control register then picks a table entry by index, says how many data bytes follow (if any) and starts the command. The block drives a mode-0 SPI bus: chip select low, opcode, optional three address bytes sent most significant first, then write data taken from the staging buffer or read data stored back into it.

A prefix byte, usually a write-enable opcode, can be bound to the command. When the prefix is nonzero and the control word asks for it, the prefix goes out as its own one-byte chip-select frame and the main frame follows with no chance for another command in between. A sticky lock bit freezes the opcode table, the kind table and the prefix until reset. Status shows busy, done and error. Done and error are cleared by writing 1. The SPI clock is the system clock divided by one of two parameters, chosen per command.

Top module: `flash_seq_top`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, and the status, address, opcode-table, kind-table, prefix and lock registers all read 0.
- R2: The opcode comes from table entry ctrl[6:4] (register 3 holds entries 0..3 and register 4 holds entries 4..7, entry i in byte i mod 4). Its kind is bits 2i+1:2i of register 5: 0 read without address, 1 write without address, 2 read with address, 3 write with address. For kinds 2 and 3 the three low address bytes follow MSB first. Address bits above 23 are ignored and read back as 0.
- R3: When ctrl bit 14 is set, a write kind sends ctrl[13:8]+1 bytes (1 to 64) from buffer byte 0 upward, each byte MSB first.
- R4: When ctrl bit 14 is set, a read kind clocks ctrl[13:8]+1 bytes in on rising SCLK, holds MOSI low meanwhile, and stores them from buffer byte 0 upward, MSB first.
- R5: When ctrl bit 14 is clear, the frame has only the opcode and, for kinds 2 and 3, the address bytes.
- R6: If ctrl bit 1 is set and the prefix register (6) is nonzero, the prefix goes out alone in a one-byte frame before the main frame. Otherwise no prefix frame is sent.
- R7: Status (register 1) bit 0 is busy from the cycle after a go write (ctrl bit 0) until chip select rises at the end. Bit 1 (done) is set at completion. Bits 1 and 2 clear when 1 is written to them.
- R8: A go write while busy sets status bit 2 and starts no new frame.
- R9: Writing 1 to bit 0 of register 7 sets a lock that software cannot clear. While it is set, writes to registers 3 to 6 are ignored.
- R10: An SCLK half period lasts DIV_FAST system clocks when ctrl bit 2 is set, otherwise DIV_SLOW. SCLK is low while chip select is high. Chip select falls one SCLK period before the first rising edge and rises one SCLK period after the last falling edge.
- R11: Register reads return data one clock after the address is presented. Word k of the data window (address 16+k) holds buffer bytes 4k..4k+3, with byte 4k in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register word address (bit ADDR_W-1 selects the data window) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data |
| spi_sclk | output | 1 | SPI clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
A register read is due one clock after its address is applied. The bench reads at the falling edge that follows, and it polls busy rather than predicting how long a frame takes. On every clock the bench counts system clocks between SPI events and compares each interval with what R10 requires for the divider in force: two half periods from chip-select fall to the first rise, one half period between SCLK edges, and two from the last fall to chip-select rise. A slave model records every frame, and each frame is compared byte by byte with the expected opcode, address and data, including read bytes stored back in the buffer.

// File: rtl/seq_pkg.sv
package seq_pkg;
  localparam int SEQ_CNT_W = 6;
  localparam int MENU_N    = 8;

  localparam int REG_CTRL = 0;
  localparam int REG_STAT = 1;
  localparam int REG_ADDR = 2;
  localparam int REG_MLO  = 3;
  localparam int REG_MHI  = 4;
  localparam int REG_KIND = 5;
  localparam int REG_PREF = 6;
  localparam int REG_LOCK = 7;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_SHIFT, ST_HOLD, ST_GAP
  } eng_state_t;

  typedef struct packed {
    logic [7:0]           opcode;
    logic [1:0]           kind;
    logic                 pre_en;
    logic [7:0]           pre_op;
    logic [23:0]          addr;
    logic                 has_data;
    logic [SEQ_CNT_W-1:0] nbytes;
    logic                 fast;
  } cyc_cfg_t;
endpackage

// File: rtl/seq_regs.sv
module seq_regs
  import seq_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 we,
  input  logic [ADDR_W-1:0]    addr,
  input  logic [31:0]          wdata,
  output logic [31:0]          rdata,
  output logic                 start,
  output cyc_cfg_t             cfg,
  input  logic                 eng_busy,
  input  logic                 eng_done,
  input  logic [SEQ_CNT_W-1:0] eng_ridx,
  output logic [7:0]           eng_rbyte,
  input  logic                 eng_we,
  input  logic [SEQ_CNT_W-1:0] eng_widx,
  input  logic [7:0]           eng_wbyte
);
  localparam int BYTES  = 1 << SEQ_CNT_W;
  localparam int WIDX_W = SEQ_CNT_W - 2;
  localparam int OFF_W  = ADDR_W - 1;

  logic [7:0]           dbuf [BYTES];
  logic [8*MENU_N-1:0]  menu_q;
  logic [2*MENU_N-1:0]  kind_q;
  logic [7:0]           pref_q;
  logic [23:0]          addr_q;
  logic                 atom_q, fast_q, data_q;
  logic [2:0]           idx_q;
  logic [SEQ_CNT_W-1:0] cnt_q;
  logic                 done_q, err_q, lock_q;

  logic              in_win;
  logic [OFF_W-1:0]  roff;
  logic [WIDX_W-1:0] widx;
  logic              busy_eff;
  logic              reg_wr;

  assign in_win   = addr[ADDR_W-1];
  assign roff     = addr[OFF_W-1:0];
  assign widx     = addr[WIDX_W-1:0];
  assign busy_eff = eng_busy | start;
  assign reg_wr   = we && !in_win;

  always_comb begin
    cfg.opcode   = menu_q[8*idx_q +: 8];
    cfg.kind     = kind_q[2*idx_q +: 2];
    cfg.pre_en   = atom_q && (pref_q != 8'h00);
    cfg.pre_op   = pref_q;
    cfg.addr     = addr_q;
    cfg.has_data = data_q;
    cfg.nbytes   = cnt_q;
    cfg.fast     = fast_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      menu_q <= '0; kind_q <= '0; pref_q <= '0; addr_q <= '0;
      atom_q <= 1'b0; fast_q <= 1'b0; data_q <= 1'b0; idx_q <= '0; cnt_q <= '0;
      done_q <= 1'b0; err_q <= 1'b0; lock_q <= 1'b0; start <= 1'b0;
    end else begin
      start <= 1'b0;
      if (reg_wr) begin
        case (roff)
          OFF_W'(REG_CTRL): begin
            atom_q <= wdata[1];
            fast_q <= wdata[2];
            idx_q  <= wdata[6:4];
            cnt_q  <= wdata[8 +: SEQ_CNT_W];
            data_q <= wdata[14];
            if (wdata[0]) begin
              if (busy_eff) err_q <= 1'b1;
              else          start <= 1'b1;
            end
          end
          OFF_W'(REG_STAT): begin
            if (wdata[1]) done_q <= 1'b0;
            if (wdata[2]) err_q  <= 1'b0;
          end
          OFF_W'(REG_ADDR): addr_q <= wdata[23:0];
          OFF_W'(REG_MLO):  if (!lock_q) menu_q[31:0]  <= wdata;
          OFF_W'(REG_MHI):  if (!lock_q) menu_q[63:32] <= wdata;
          OFF_W'(REG_KIND): if (!lock_q) kind_q <= wdata[15:0];
          OFF_W'(REG_PREF): if (!lock_q) pref_q <= wdata[7:0];
          OFF_W'(REG_LOCK): if (wdata[0]) lock_q <= 1'b1;
          default: ;
        endcase
      end
      if (eng_done) done_q <= 1'b1;
    end
  end

  // Staging buffer: one write port, engine has priority, software blocked while busy
  always_ff @(posedge clk) begin
    if (eng_we) begin
      dbuf[eng_widx] <= eng_wbyte;
    end else if (we && in_win && !busy_eff) begin
      for (int b = 0; b < 4; b++) dbuf[{widx, 2'(b)}] <= wdata[8*b +: 8];
    end
  end

  assign eng_rbyte = dbuf[eng_ridx];

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (in_win) begin
      rdata <= {dbuf[{widx, 2'd3}], dbuf[{widx, 2'd2}], dbuf[{widx, 2'd1}], dbuf[{widx, 2'd0}]};
    end else begin
      case (roff)
        OFF_W'(REG_CTRL): rdata <= {17'b0, data_q, cnt_q, 1'b0, idx_q, 1'b0, fast_q, atom_q, 1'b0};
        OFF_W'(REG_STAT): rdata <= {29'b0, err_q, done_q, busy_eff};
        OFF_W'(REG_ADDR): rdata <= {8'b0, addr_q};
        OFF_W'(REG_MLO):  rdata <= menu_q[31:0];
        OFF_W'(REG_MHI):  rdata <= menu_q[63:32];
        OFF_W'(REG_KIND): rdata <= {16'b0, kind_q};
        OFF_W'(REG_PREF): rdata <= {24'b0, pref_q};
        OFF_W'(REG_LOCK): rdata <= {31'b0, lock_q};
        default:          rdata <= '0;
      endcase
    end
  end

  assert_lock_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> lock_q) else $error("lock bit dropped");

  assert_tables_frozen_R9: assert property (@(posedge clk) disable iff (rst)
    lock_q |=> ($stable(menu_q) && $stable(kind_q) && $stable(pref_q)))
    else $error("locked table changed");

  assert_done_follows_engine_R7: assert property (@(posedge clk) disable iff (rst)
    eng_done |=> done_q) else $error("done flag missed completion");

  assert_busy_go_flags_error_R8: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && roff == OFF_W'(REG_CTRL) && wdata[0] && eng_busy) |=> (err_q && !start))
    else $error("go while busy not rejected");
endmodule

// File: rtl/seq_spi_engine.sv
module seq_spi_engine
  import seq_pkg::*;
#(
  parameter int DIV_SLOW = 3,
  parameter int DIV_FAST = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  cyc_cfg_t             cfg,
  output logic                 busy,
  output logic                 done,
  output logic [SEQ_CNT_W-1:0] buf_ridx,
  input  logic [7:0]           buf_rbyte,
  output logic                 buf_we,
  output logic [SEQ_CNT_W-1:0] buf_widx,
  output logic [7:0]           buf_wbyte,
  output logic                 sclk,
  output logic                 cs_n,
  output logic                 mosi,
  input  logic                 miso
);
  localparam int DIV_MAX = (DIV_SLOW > DIV_FAST) ? DIV_SLOW : DIV_FAST;
  localparam int DIV_W   = $clog2(DIV_MAX + 1);
  localparam int TOT_W   = SEQ_CNT_W + 2;

  eng_state_t        st;
  cyc_cfg_t          cfg_q;
  logic              pre_ph, hc;
  logic [TOT_W-1:0]  bidx;
  logic [2:0]        bitc;
  logic [7:0]        sh, rx;
  logic [DIV_W-1:0]  tcnt, div;
  logic              tick;
  logic [TOT_W-1:0]  hdr, total, nidx;
  logic              rd_byte;
  logic [7:0]        next_byte;

  assign div   = cfg_q.fast ? DIV_W'(DIV_FAST) : DIV_W'(DIV_SLOW);
  assign tick  = (tcnt == div - DIV_W'(1));
  assign hdr   = cfg_q.kind[1] ? TOT_W'(4) : TOT_W'(1);
  assign total = pre_ph ? TOT_W'(1)
               : hdr + (cfg_q.has_data ? TOT_W'(cfg_q.nbytes) + TOT_W'(1) : TOT_W'(0));
  assign nidx     = bidx + TOT_W'(1);
  assign buf_ridx = SEQ_CNT_W'(nidx - hdr);
  assign rd_byte  = !pre_ph && !cfg_q.kind[0] && (bidx >= hdr);
  assign busy     = (st != ST_IDLE);
  assign mosi     = sh[7];

  always_comb begin
    if (cfg_q.kind[1] && nidx < hdr) begin
      case (nidx[1:0])
        2'd1:    next_byte = cfg_q.addr[23:16];
        2'd2:    next_byte = cfg_q.addr[15:8];
        default: next_byte = cfg_q.addr[7:0];
      endcase
    end else begin
      next_byte = cfg_q.kind[0] ? buf_rbyte : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cfg_q <= '0; pre_ph <= 1'b0; hc <= 1'b0;
      bidx <= '0; bitc <= '0; sh <= '0; rx <= '0; tcnt <= '0;
      sclk <= 1'b0; cs_n <= 1'b1; done <= 1'b0;
      buf_we <= 1'b0; buf_widx <= '0; buf_wbyte <= '0;
    end else begin
      done   <= 1'b0;
      buf_we <= 1'b0;
      if (st != ST_IDLE) tcnt <= tick ? '0 : tcnt + DIV_W'(1);
      case (st)
        ST_IDLE: if (start) begin
          cfg_q  <= cfg;
          pre_ph <= cfg.pre_en;
          sh     <= cfg.pre_en ? cfg.pre_op : cfg.opcode;
          cs_n   <= 1'b0;
          bidx   <= '0;
          bitc   <= '0;
          tcnt   <= '0;
          st     <= ST_SETUP;
        end
        ST_SETUP: if (tick) st <= ST_SHIFT;
        ST_SHIFT: if (tick) begin
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[6:0], miso};
            if (bitc == 3'd7 && rd_byte) begin
              buf_we    <= 1'b1;
              buf_widx  <= SEQ_CNT_W'(bidx - hdr);
              buf_wbyte <= {rx[6:0], miso};
            end
          end else begin
            sclk <= 1'b0;
            bitc <= bitc + 3'd1;
            if (bitc == 3'd7) begin
              if (nidx == total) begin
                st <= ST_HOLD;
                hc <= 1'b0;
                sh <= 8'h00;
              end else begin
                bidx <= nidx;
                sh   <= next_byte;
              end
            end else begin
              sh <= {sh[6:0], 1'b0};
            end
          end
        end
        ST_HOLD: if (tick) begin
          hc <= ~hc;
          if (hc) begin
            cs_n <= 1'b1;
            if (pre_ph) begin
              pre_ph <= 1'b0;
              st     <= ST_GAP;
            end else begin
              st   <= ST_IDLE;
              done <= 1'b1;
            end
          end
        end
        ST_GAP: if (tick) begin
          hc <= ~hc;
          if (hc) begin
            cs_n <= 1'b0;
            bidx <= '0;
            bitc <= '0;
            sh   <= cfg_q.opcode;
            st   <= ST_SETUP;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_sclk_low_deselected_R10: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk) else $error("SCLK high with chip select high");

  assert_no_start_when_busy_R8: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy) else $error("start issued during active cycle");

  assert_cs_idle_high_R7: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n) else $error("chip select low while idle");

  assert_done_ends_busy_R7: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && cs_n)) else $error("done while still active");
endmodule

// File: rtl/flash_seq_top.sv
module flash_seq_top
  import seq_pkg::*;
#(
  parameter int ADDR_W   = 5,
  parameter int DIV_SLOW = 3,
  parameter int DIV_FAST = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              spi_sclk,
  output logic              spi_cs_n,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  cyc_cfg_t             cfg;
  logic                 start, eng_busy, eng_done, eng_we;
  logic [SEQ_CNT_W-1:0] ridx, widx;
  logic [7:0]           rbyte, wbyte;

  seq_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .rdata(reg_rdata), .start(start), .cfg(cfg), .eng_busy(eng_busy),
    .eng_done(eng_done), .eng_ridx(ridx), .eng_rbyte(rbyte),
    .eng_we(eng_we), .eng_widx(widx), .eng_wbyte(wbyte)
  );

  seq_spi_engine #(.DIV_SLOW(DIV_SLOW), .DIV_FAST(DIV_FAST)) u_eng (
    .clk(clk), .rst(rst), .start(start), .cfg(cfg), .busy(eng_busy),
    .done(eng_done), .buf_ridx(ridx), .buf_rbyte(rbyte), .buf_we(eng_we),
    .buf_widx(widx), .buf_wbyte(wbyte), .sclk(spi_sclk), .cs_n(spi_cs_n),
    .mosi(spi_mosi), .miso(spi_miso)
  );
endmodule

// File: tb/flash_seq_top_test.sv
module flash_seq_top_test;
  localparam int CLK_PERIOD = 10;
  localparam int DSLOW = 3;
  localparam int DFAST = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [4:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic spi_sclk, spi_cs_n, spi_mosi;
  logic spi_miso = 1'b0;

  int checks = 0;
  int fails = 0;
  int cur_div = DSLOW;

  flash_seq_top #(.ADDR_W(5), .DIV_SLOW(DSLOW), .DIV_FAST(DFAST)) uut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
    .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] resp(int p);
    return 8'(p * 29 + 60);
  endfunction

  // Flash slave model: records every frame, answers with resp(position)
  logic [7:0] cap_q[$];
  int flen_q[$];
  logic [7:0] exp_b[$];
  int exp_l[$];
  int bitn = 0;
  int cur_len = 0;
  logic [7:0] shreg = '0;

  always @(negedge spi_cs_n) begin
    bitn = 0; cur_len = 0;
    spi_miso = resp(0)[7];
  end
  always @(posedge spi_sclk) if (!spi_cs_n) begin
    shreg = {shreg[6:0], spi_mosi};
    bitn++;
    if (bitn % 8 == 0) begin cap_q.push_back(shreg); cur_len++; end
  end
  always @(negedge spi_sclk) if (!spi_cs_n) spi_miso = resp(bitn / 8)[7 - (bitn % 8)];
  always @(posedge spi_cs_n) if (!rst) flen_q.push_back(cur_len);

  // Per-clock timing reference (R10)
  logic pcs = 1'b1, psc = 1'b0, first_rise = 1'b0;
  int since = 0;
  always @(negedge clk) if (!rst) begin
    since++;
    if (spi_cs_n) chk("R10 sclk low while deselected", {31'b0, spi_sclk}, 32'd0);
    if (pcs && !spi_cs_n) begin since = 0; first_rise = 1'b1; end
    else if (!pcs && spi_cs_n) begin chk("R10 cs hold", since, 2*cur_div); since = 0; end
    else if (!psc && spi_sclk) begin
      chk(first_rise ? "R10 cs setup" : "R10 sclk low half", since, first_rise ? 2*cur_div : cur_div);
      first_rise = 1'b0; since = 0;
    end else if (psc && !spi_sclk) begin chk("R10 sclk high half", since, cur_div); since = 0; end
    pcs = spi_cs_n; psc = spi_sclk;
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = 5'(a); reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(int a, output logic [31:0] d);
    @(negedge clk); reg_addr = 5'(a);
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(1, v);
      if (!v[0]) break;
    end
  endtask

  task automatic frame(logic [7:0] b[$]);
    foreach (b[i]) exp_b.push_back(b[i]);
    exp_l.push_back(b.size());
  endtask

  task automatic cmp_frames(string tag);
    chk({tag, " frame count"}, flen_q.size(), exp_l.size());
    foreach (exp_l[i]) if (i < flen_q.size()) chk({tag, " frame length"}, flen_q[i], exp_l[i]);
    chk({tag, " byte count"}, cap_q.size(), exp_b.size());
    foreach (exp_b[i]) if (i < cap_q.size()) chk({tag, " byte"}, {24'b0, cap_q[i]}, {24'b0, exp_b[i]});
    cap_q.delete(); flen_q.delete(); exp_b.delete(); exp_l.delete();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic [7:0] big[$];
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 cs_n", {31'b0, spi_cs_n}, 32'd1);
    chk("R1 sclk/mosi", {30'b0, spi_sclk, spi_mosi}, 32'd0);
    rd(1, v); chk("R1 status", v, 0);
    rd(3, v); chk("R1 table", v, 0);
    rd(7, v); chk("R1 lock", v, 0);

    // table: 0:06 k1, 1:02 k3, 2:03 k2, 3:05 k0, 4:20 k3, 5:01 k1
    wr(3, 32'h05030206); wr(4, 32'h00000120); wr(5, 32'h072D); wr(6, 32'h06);
    wr(2, 32'hFF123456); rd(2, v); chk("R2 address upper bits ignored", v, 32'h123456);
    wr(16, 32'hDDCCBBAA);

    // R6 atomic prefix + R2 address + R3 write data
    wr(0, 32'h4313); wait_idle();
    frame('{8'h06}); frame('{8'h02, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hBB, 8'hCC, 8'hDD});
    cmp_frames("R6 R3 prefixed write");
    rd(1, v); chk("R7 done after cycle", v, 32'h2);
    wr(1, 32'h2); rd(1, v); chk("R7 done W1C", v, 0);

    // R6 no prefix without atomic bit
    wr(0, 32'h4311); wait_idle();
    frame('{8'h02, 8'h12, 8'h34, 8'h56, 8'hAA, 8'hBB, 8'hCC, 8'hDD});
    cmp_frames("R6 non-atomic");

    // R4 read with address
    wr(2, 32'h001000); wr(0, 32'h4221); wait_idle();
    frame('{8'h03, 8'h00, 8'h10, 8'h00, 8'h00, 8'h00, 8'h00});
    cmp_frames("R4 read frame");
    rd(16, v); chk("R4 read bytes stored", v & 32'hFFFFFF, {8'h0, resp(6), resp(5), resp(4)});

    // R4/R2 read without address
    wr(0, 32'h4031); wait_idle();
    frame('{8'h05, 8'h00}); cmp_frames("R4 status read");
    rd(16, v); chk("R4 byte0 no-address read", {24'b0, v[7:0]}, {24'b0, resp(1)});

    // R5 no-data erase
    wr(0, 32'h41); wait_idle();
    frame('{8'h20, 8'h00, 8'h10, 8'h00}); cmp_frames("R5 erase");

    // R10 fast clock, R3 write without address
    wr(16, 32'h000000E7);
    cur_div = DFAST; wr(0, 32'h4055); wait_idle();
    frame('{8'h01, 8'hE7}); cmp_frames("R10 R3 fast write");
    cur_div = DSLOW;

    // R3 64-byte boundary, R11 data window
    for (int k = 0; k < 16; k++)
      wr(16 + k, {8'(4*k+3) ^ 8'h55, 8'(4*k+2) ^ 8'h55, 8'(4*k+1) ^ 8'h55, 8'(4*k) ^ 8'h55});
    rd(17, v); chk("R11 window word 1", v, {8'h07 ^ 8'h55, 8'h06 ^ 8'h55, 8'h05 ^ 8'h55, 8'h04 ^ 8'h55});
    wr(2, 32'h123456); wr(0, 32'h7F11); wait_idle();
    big = '{8'h02, 8'h12, 8'h34, 8'h56};
    for (int j = 0; j < 64; j++) big.push_back(8'(j) ^ 8'h55);
    frame(big); cmp_frames("R3 64-byte write");
    wr(1, 32'h2);

    // R8 go while busy
    wr(0, 32'h41); rd(1, v); chk("R7 busy after go", {31'b0, v[0]}, 32'd1);
    wr(0, 32'h41); wait_idle();
    rd(1, v); chk("R8 error and done", v, 32'h6);
    frame('{8'h20, 8'h12, 8'h34, 8'h56}); cmp_frames("R8 single frame");
    wr(1, 32'h2); rd(1, v); chk("R7 error kept", v, 32'h4);
    wr(1, 32'h4); rd(1, v); chk("R7 error W1C", v, 0);

    // R9 lockdown
    wr(7, 32'h1);
    wr(3, 32'hFFFFFFFF); rd(3, v); chk("R9 table frozen", v, 32'h05030206);
    wr(5, 32'h0); rd(5, v); chk("R9 kinds frozen", v, 32'h072D);
    wr(6, 32'h99); rd(6, v); chk("R9 prefix frozen", v, 32'h06);
    wr(7, 32'h0); rd(7, v); chk("R9 lock sticky", v, 32'h1);
    wr(0, 32'h01); wait_idle();
    frame('{8'h06}); cmp_frames("R9 locked table still used");

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule